// File: doc/BRIEF.md
# Strip-Mining Vector Address Generator

This block splits a vector operation of arbitrary length into a series of hardware vector operations. Each of them is no longer than the machine's maximum vector length of 64 elements. A single start pulse supplies a base address, an element count, a signed stride, an element size and an access mode. The block then announces each strip with a vector-length value and a one-cycle marker. After the marker it emits one memory address per element over a valid/ready stream. When every element has been handed off, it raises a done pulse.

If the count is not a multiple of 64, the shorter remainder strip goes first and full 64-element strips follow. The length travels on its own output next to the addresses, so downstream arithmetic takes its element count from that value and not from an opcode.

In strided mode the address is a running sum that carries across strip boundaries, so each new strip begins exactly where the previous one ended. In indexed mode each address is a fixed base plus an offset. The offset is taken one per element from an index stream and scaled by the element size. The vector register file and the arithmetic units that consume the strips are outside this block.

Top module: `vec_strip_agu`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `strip_start`, `addr_valid`, `addr_last` and `idx_ready` are all low.
- R2: A start with an element count of zero gives a `done` pulse on the cycle after start. No `strip_start` and no address come out for it.
- R3: The first strip's `vl_out` is the count modulo 64, or 64 when the count is a nonzero multiple of 64. Every later strip has length 64. `vl_out` holds steady until the next strip is announced.
- R4: In strided mode (`indexed` = 0), overall element j has address base + j * stride * 2^size, truncated to the address width. The stride is two's-complement signed. Element numbering runs across strips, so each strip base is the previous one plus VL * stride * 2^size.
- R5: In indexed mode (`indexed` = 1), each address is base + (index << size), with the index unsigned. `addr_valid` follows `idx_valid` during a strip. `idx_ready` is high exactly when an emitted address can be accepted, so each accepted address uses up one index.
- R6: In strided mode, while `addr_valid` is high and `addr_ready` is low, `addr_valid` stays high and `addr_data` keeps its value.
- R7: `strip_start` is a one-cycle pulse. It comes before each strip's first element, with `vl_out` already showing that strip's length, and no address is valid during it. `addr_last` is high on exactly the final element of each strip.
- R8: `done` pulses for one cycle, on the cycle after the last element is accepted. `busy` is low from the next cycle on.
- R9: A start pulse while `busy` is high is ignored. The running operation's lengths and addresses do not change.
- R10: `size` encodes the element width as a power of two: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes. A contiguous 64-element strip of 8-byte elements spans 512 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins an operation when idle |
| base_addr | input | ADDR_W | Starting byte address |
| elem_count | input | CNT_W | Total elements in the operation |
| stride | input | STRIDE_W | Signed element stride, in elements |
| size | input | 2 | log2 of element size in bytes |
| indexed | input | 1 | 1 selects indexed addressing, 0 selects strided |
| idx_valid | input | 1 | Index stream valid |
| idx_data | input | IDX_W | Unsigned element index |
| idx_ready | output | 1 | Index taken on this cycle when valid |
| vl_out | output | VL_W | Length of the current strip |
| strip_start | output | 1 | One-cycle marker before each strip |
| addr_valid | output | 1 | Element address valid |
| addr_ready | input | 1 | Downstream accepts the address |
| addr_data | output | ADDR_W | Element byte address |
| addr_last | output | 1 | Final element of the current strip |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The properties assume that `indexed` stays constant from start until done. The stall-hold check also relies on the index source not being observed in strided mode. The stimulus drives all operation inputs before each start and changes `indexed` only between operations. The one start pulse sent mid-operation keeps the mode unchanged and alters only the count, base, stride and size. Random back-pressure and random index-valid gaps exercise the stall paths, and the index data changes freely because indexed-mode address stability is never asserted.

// File: rtl/vsa_pkg.sv
package vsa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STRIP = 2'd1,
        ST_ELEM  = 2'd2,
        ST_DONE  = 2'd3
    } vsa_state_e;

    localparam int unsigned SZ_W = 2;

endpackage

// File: rtl/vsa_strip_sizer.sv
module vsa_strip_sizer #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned MAX_VL = 64
) (
    input  logic [CNT_W-1:0]              count_i,
    output logic [$clog2(MAX_VL):0]       first_vl_o,
    output logic                          zero_o
);
    localparam int unsigned LOG_VL = $clog2(MAX_VL);
    localparam int unsigned VL_W   = LOG_VL + 1;

    logic [LOG_VL-1:0] leftover;

    // MAX_VL is a power of two, so the remainder is a plain bit slice
    assign leftover   = count_i[LOG_VL-1:0];
    assign zero_o     = (count_i == '0);
    assign first_vl_o = (leftover == '0) ? VL_W'(MAX_VL) : VL_W'(leftover);

endmodule

// File: rtl/vsa_addr_unit.sv
module vsa_addr_unit #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned STRIDE_W = 16,
    parameter int unsigned IDX_W    = 16
) (
    input  logic [STRIDE_W-1:0] stride_i,
    input  logic [1:0]          new_size_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [ADDR_W-1:0]   run_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic [1:0]          size_i,
    input  logic                mode_idx_i,
    output logic [ADDR_W-1:0]   step_o,
    output logic [ADDR_W-1:0]   addr_o
);
    logic [ADDR_W-1:0] stride_ext;
    logic [ADDR_W-1:0] idx_ext;
    logic [ADDR_W-1:0] idx_off;

    assign stride_ext = {{(ADDR_W-STRIDE_W){stride_i[STRIDE_W-1]}}, stride_i};
    assign step_o     = stride_ext << new_size_i;
    assign idx_ext    = {{(ADDR_W-IDX_W){1'b0}}, idx_i};
    assign idx_off    = idx_ext << size_i;
    assign addr_o     = mode_idx_i ? (base_i + idx_off) : run_i;

endmodule

// File: rtl/vec_strip_agu.sv
module vec_strip_agu
    import vsa_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned STRIDE_W = 16,
    parameter int unsigned IDX_W    = 16,
    parameter int unsigned MAX_VL   = 64,
    localparam int unsigned VL_W    = $clog2(MAX_VL) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  elem_count,
    input  logic [STRIDE_W-1:0] stride,
    input  logic [1:0]        size,
    input  logic              indexed,
    input  logic              idx_valid,
    input  logic [IDX_W-1:0]  idx_data,
    output logic              idx_ready,
    output logic [VL_W-1:0]   vl_out,
    output logic              strip_start,
    output logic              addr_valid,
    input  logic              addr_ready,
    output logic [ADDR_W-1:0] addr_data,
    output logic              addr_last,
    output logic              busy,
    output logic              done
);

    typedef struct packed {
        vsa_state_e        st;
        logic [CNT_W-1:0]  rem;
        logic [VL_W-1:0]   vl;
        logic [VL_W-1:0]   k;
        logic [ADDR_W-1:0] run;
        logic [ADDR_W-1:0] step;
        logic [ADDR_W-1:0] base;
        logic [1:0]        sz;
        logic              mode_idx;
    } regs_t;

    regs_t q, d;

    logic [VL_W-1:0]   first_vl;
    logic              count_zero;
    logic [ADDR_W-1:0] step_new;
    logic [ADDR_W-1:0] elem_addr;
    logic              in_elem;
    logic              fire;
    logic              strip_end;

    vsa_strip_sizer #(
        .CNT_W  (CNT_W),
        .MAX_VL (MAX_VL)
    ) sizer_i (
        .count_i    (elem_count),
        .first_vl_o (first_vl),
        .zero_o     (count_zero)
    );

    vsa_addr_unit #(
        .ADDR_W   (ADDR_W),
        .STRIDE_W (STRIDE_W),
        .IDX_W    (IDX_W)
    ) addr_i (
        .stride_i   (stride),
        .new_size_i (size),
        .base_i     (q.base),
        .run_i      (q.run),
        .idx_i      (idx_data),
        .size_i     (q.sz),
        .mode_idx_i (q.mode_idx),
        .step_o     (step_new),
        .addr_o     (elem_addr)
    );

    assign in_elem   = (q.st == ST_ELEM);
    assign strip_end = (q.k == q.vl - VL_W'(1));
    assign fire      = addr_valid && addr_ready;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.base     = base_addr;
                    d.run      = base_addr;
                    d.step     = step_new;
                    d.sz       = size;
                    d.mode_idx = indexed;
                    d.rem      = elem_count;
                    d.k        = '0;
                    if (count_zero) begin
                        d.st = ST_DONE;
                    end else begin
                        d.vl = first_vl;
                        d.st = ST_STRIP;
                    end
                end
            end
            ST_STRIP: begin
                d.st = ST_ELEM;
            end
            ST_ELEM: begin
                if (fire) begin
                    d.run = q.run + q.step;
                    if (strip_end) begin
                        d.k   = '0;
                        d.rem = q.rem - CNT_W'(q.vl);
                        if (q.rem == CNT_W'(q.vl)) begin
                            d.st = ST_DONE;
                        end else begin
                            d.vl = VL_W'(MAX_VL);
                            d.st = ST_STRIP;
                        end
                    end else begin
                        d.k = q.k + VL_W'(1);
                    end
                end
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy        = (q.st != ST_IDLE);
    assign done        = (q.st == ST_DONE);
    assign strip_start = (q.st == ST_STRIP);
    assign vl_out      = q.vl;
    assign addr_valid  = in_elem && (!q.mode_idx || idx_valid);
    assign idx_ready   = in_elem && q.mode_idx && addr_ready;
    assign addr_data   = elem_addr;
    assign addr_last   = in_elem && strip_end;

endmodule

module vsa_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned MAX_VL = 64,
    parameter int unsigned VL_W   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              indexed,
    input logic              idx_ready,
    input logic [VL_W-1:0]   vl_out,
    input logic              strip_start,
    input logic              addr_valid,
    input logic              addr_ready,
    input logic [ADDR_W-1:0] addr_data,
    input logic              busy,
    input logic              done
);
    // R3
    vl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strip_start |-> (vl_out != '0) && (vl_out <= VL_W'(MAX_VL)));

    // R3
    vl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !strip_start) |-> $stable(vl_out));

    // R7
    strip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strip_start |-> !addr_valid);

    // R7
    strip_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strip_start |=> !strip_start);

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready && !indexed) |=> addr_valid && $stable(addr_data));

    // R5
    idx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_ready |-> busy && indexed && !strip_start);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R2
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !addr_valid && !strip_start);

endmodule

bind vec_strip_agu vsa_chk #(
    .ADDR_W (ADDR_W),
    .MAX_VL (MAX_VL),
    .VL_W   ($clog2(MAX_VL) + 1)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .indexed     (indexed),
    .idx_ready   (idx_ready),
    .vl_out      (vl_out),
    .strip_start (strip_start),
    .addr_valid  (addr_valid),
    .addr_ready  (addr_ready),
    .addr_data   (addr_data),
    .busy        (busy),
    .done        (done)
);

// File: tb/vec_strip_agu_tb_top.sv
module vec_strip_agu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] elem_count = '0;
    logic [15:0] stride = '0;
    logic [1:0]  size = '0;
    logic        indexed = 1'b0;
    logic        idx_valid = 1'b0;
    logic [15:0] idx_data = '0;
    logic        idx_ready;
    logic [6:0]  vl_out;
    logic        strip_start;
    logic        addr_valid;
    logic        addr_ready = 1'b0;
    logic [31:0] addr_data;
    logic        addr_last;
    logic        busy;
    logic        done;

    int n_chk  = 0;
    int n_fail = 0;

    vec_strip_agu dut_i (
        .clk (clk), .rst_n (rst_n), .start (start), .base_addr (base_addr),
        .elem_count (elem_count), .stride (stride), .size (size),
        .indexed (indexed), .idx_valid (idx_valid), .idx_data (idx_data),
        .idx_ready (idx_ready), .vl_out (vl_out), .strip_start (strip_start),
        .addr_valid (addr_valid), .addr_ready (addr_ready),
        .addr_data (addr_data), .addr_last (addr_last), .busy (busy),
        .done (done)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_strided(input logic [31:0] b, input int j,
                                                input logic [15:0] s, input int sz);
        longint off;
        off = longint'(j) * longint'($signed(s)) * (longint'(1) << sz);
        return b + off[31:0];
    endfunction

    function automatic logic [31:0] exp_indexed(input logic [31:0] b,
                                                input logic [15:0] ix, input int sz);
        return b + ({16'd0, ix} << sz);
    endfunction

    function automatic int first_len(input int n);
        return (n % 64 == 0) ? 64 : n % 64;
    endfunction

    task automatic run_op(input logic [31:0] b, input int n, input logic [15:0] s,
                          input int sz, input bit idx_mode, input int rdy_pct,
                          input bit poke_start);
        int rem, vl, k, j, cyc;
        bit need_strip, stalled, finished;
        logic [31:0] held, expa;
        @(negedge clk);
        base_addr = b; elem_count = 16'(n); stride = s; size = 2'(sz);
        indexed = idx_mode; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            #1;
            check(done == 1'b1, "R2", "done after zero count", done, 1);
            check(!strip_start && !addr_valid, "R2", "no strip/addr", {strip_start, addr_valid}, 0);
            @(negedge clk); #1;
            check(!busy && !done, "R8", "idle after done", {busy, done}, 0);
            return;
        end
        rem = n; vl = first_len(n); k = 0; j = 0; cyc = 0;
        need_strip = 1'b1; stalled = 1'b0; finished = 1'b0;
        while (!finished) begin
            addr_ready = ($urandom_range(0, 99) < rdy_pct);
            if (idx_mode) begin
                idx_valid = ($urandom_range(0, 99) < 70);
                idx_data  = 16'($urandom_range(0, 65535));
            end else begin
                idx_valid = 1'b0;
            end
            if (poke_start && cyc == 5) begin
                start = 1'b1; elem_count = 16'd3; base_addr = 32'h0;
                stride = 16'd7; size = 2'd0;
            end else begin
                start = 1'b0;
            end
            #1;
            if (need_strip) begin
                check(strip_start == 1'b1, "R7", "strip_start pulse", strip_start, 1);
                check(vl_out == 7'(vl), "R3", "strip length", vl_out, vl);
                check(!addr_valid, "R7", "no addr during strip marker", addr_valid, 0);
                need_strip = 1'b0;
            end else begin
                check(strip_start == 1'b0, "R7", "strip_start single cycle", strip_start, 0);
                check(vl_out == 7'(vl), "R3", "length held", vl_out, vl);
                if (idx_mode)
                    check(addr_valid == idx_valid, "R5", "valid follows index", addr_valid, idx_valid);
                else
                    check(addr_valid == 1'b1, "R4", "strided valid", addr_valid, 1);
                if (stalled)
                    check(addr_data == held, "R6", "held address under stall", addr_data, held);
                stalled = addr_valid && !addr_ready && !idx_mode;
                held = addr_data;
                if (idx_mode)
                    check(idx_ready == (addr_ready && 1'b1), "R5", "idx_ready", idx_ready, addr_ready);
                if (addr_valid && addr_ready) begin
                    expa = idx_mode ? exp_indexed(b, idx_data, sz) : exp_strided(b, j, s, sz);
                    check(addr_data == expa, idx_mode ? "R5" : "R4", "address", addr_data, expa);
                    check(addr_last == (k == vl - 1), "R7", "addr_last", addr_last, k == vl - 1);
                    k++; j++;
                    if (k == vl) begin
                        rem -= vl; k = 0;
                        if (rem == 0) finished = 1'b1;
                        else begin vl = 64; need_strip = 1'b1; end
                    end
                end
            end
            cyc++;
            if (cyc > 20000) begin
                check(1'b0, "R8", "operation never completed", cyc, 0);
                finished = 1'b1;
            end
            @(negedge clk);
        end
        start = 1'b0; addr_ready = 1'b0; idx_valid = 1'b0;
        #1;
        check(done == 1'b1, "R8", "done after last element", done, 1);
        check(!addr_valid, "R8", "no address with done", addr_valid, 0);
        check(j == n, poke_start ? "R9" : "R3", "element total", j, n);
        @(negedge clk); #1;
        check(!busy && !done, "R8", "idle after done", {busy, done}, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "R8", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !done && !strip_start && !addr_valid && !addr_last && !idx_ready,
              "R1", "reset idle", {busy, done, strip_start, addr_valid, addr_last, idx_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(!busy && !addr_valid, "R1", "idle after reset release", {busy, addr_valid}, 0);

        // directed corners
        run_op(32'h1000, 0, 16'd1, 3, 1'b0, 100, 1'b0);     // R2
        run_op(32'h1000, 1, 16'd1, 3, 1'b0, 100, 1'b0);
        run_op(32'h2000, 64, 16'd1, 3, 1'b0, 100, 1'b0);    // R10: 512 bytes
        check(exp_strided(32'h2000, 64, 16'd1, 3) == 32'h2200, "R10", "64x8B span", 0, 32'h200);
        run_op(32'h3000, 63, 16'd2, 2, 1'b0, 60, 1'b0);
        run_op(32'h4000, 65, 16'd1, 1, 1'b0, 50, 1'b0);     // R3 leftover first
        run_op(32'h5000, 128, 16'd3, 0, 1'b0, 70, 1'b0);    // R3 multiples only
        run_op(32'h0000_0100, 200, 16'hFFFD, 3, 1'b0, 50, 1'b0); // R4 negative stride wraps
        run_op(32'h8000, 70, 16'd0, 2, 1'b1, 60, 1'b0);     // R5
        run_op(32'h9000, 150, 16'd1, 3, 1'b0, 80, 1'b1);    // R9
        run_op(32'hA000, 130, 16'd1, 2, 1'b1, 80, 1'b1);    // R9 indexed

        for (int i = 0; i < 25; i++) begin
            run_op($urandom(), $urandom_range(0, 300),
                   16'($signed($urandom_range(0, 80)) - 40),
                   $urandom_range(0, 3), 1'($urandom_range(0, 1)),
                   $urandom_range(30, 100), 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule